// File: doc/BRIEF.md
# DSP Address Generation Unit

This unit produces one data-memory address per request for a signal-processing core. It holds a small file of address register sets. Each set has a pointer, a modify amount, a circular-buffer length and a circular-buffer base. A request names a set, an addressing mode, an access size and a signed immediate. The unit returns the address one cycle later with a valid strobe and a misalignment fault flag. In the same clock edge it writes the updated pointer back into the set. Because the write-back lands in the same edge as the registered result, a request may be issued every cycle, and each request sees the pointer left by the one before it.

The unit supports the following addressing modes:
- plain register-indirect access
- post-increment and post-decrement by the access size
- immediate offset
- stack push, which decrements first, and stack pop, which increments afterwards
- post-modify by the modify register, with circular wrap
- bit-reversed post-modify, for FFT-style reordering

Register contents are loaded through a simple configuration write port. Memory access itself and instruction decode lie outside this block.

Top module: `dsp_agu`

## Requirements
- R1: A request accepted in cycle N raises `valid_o` in cycle N+1 with that request's address and fault. A cycle without a request gives `valid_o` and `fault_o` low in the next cycle. Requests may follow back to back, and each request sees the pointer written back by the previous one. Reset drives `valid_o`, `fault_o` and `addr_o` to zero.
- R2: Mode 0 (indirect) outputs the pointer and leaves it unchanged.
- R3: Mode 1 (post-increment) and mode 2 (post-decrement) output the old pointer. They write back the pointer plus or minus the access size in bytes (1, 2 or 4), with the circular rule of R6 applied.
- R4: Mode 3 (offset) outputs the pointer plus the sign-extended immediate and leaves the pointer unchanged.
- R5: Mode 4 (push) subtracts the access size from the pointer, then outputs that value and writes it back. Mode 5 (pop) outputs the old pointer and writes back the pointer plus the size. Neither mode wraps.
- R6: Mode 6 (modify) outputs the old pointer and writes back the pointer plus the modify register, read as two's complement. In modes 1, 2 and 6, when the length is non-zero, an updated value at or above base+length has the length subtracted, and an updated value below base has the length added. A length of zero disables the wrap.
- R7: Mode 7 (bit-reversed) outputs the old pointer and writes back the sum of pointer and modify register, with the carry running from the most significant bit toward bit 0.
- R8: Size code 0 is a byte, 1 a half-word and 2 a word; code 3 is invalid. The fault flag is set when the output address has bit 0 set for a half-word, has either of bits 1:0 set for a word, or when the size code is 3. A faulting request still outputs its address, but its pointer write-back is suppressed.
- R9: A configuration write stores `cfg_data_i` into field `cfg_fld_i` of set `cfg_sel_i`. The field codes are 0 pointer, 1 modify, 2 length and 3 base. A request in the next cycle sees the new value. Reset clears every field to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | SEL_W | Register set to write |
| cfg_fld_i | input | 2 | Field code: 0 pointer, 1 modify, 2 length, 3 base |
| cfg_data_i | input | AW | Value to write |
| req_i | input | 1 | Address request |
| mode_i | input | 3 | Addressing mode 0..7 |
| sel_i | input | SEL_W | Register set used by the request |
| size_i | input | 2 | Access size code |
| imm_i | input | IMM_W | Signed immediate offset for mode 3 |
| addr_o | output | AW | Generated address |
| valid_o | output | 1 | Address valid, one cycle after the request |
| fault_o | output | 1 | Misalignment or invalid size fault |

## Verification
The assertions assume that a configuration write and a request never occur in the same cycle. They also assume that a circular window never straddles the top of the address space, and that each circular step is no larger than its window length. The stimulus keeps to these limits in the following ways:
- Configuration writes are issued only in cycles that carry no request.
- Each circular set gets a low base, a small length, and a modify value whose size stays within the length.
- Free-running random traffic is confined to sets with zero length, where the pointer may roll over freely.

// File: rtl/dsp_agu_pkg.sv
// Package: shared mode, size and field encodings for the address generator.
// Assumes the encodings listed in the brief; neighbours decode these values.
package dsp_agu_pkg;
    typedef enum logic [2:0] {
        AM_IND     = 3'd0,
        AM_POSTINC = 3'd1,
        AM_POSTDEC = 3'd2,
        AM_OFFSET  = 3'd3,
        AM_PUSH    = 3'd4,
        AM_POP     = 3'd5,
        AM_MODIFY  = 3'd6,
        AM_BITREV  = 3'd7
    } agu_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } agu_size_e;

    typedef enum logic [1:0] {
        FLD_PTR  = 2'd0,
        FLD_MOD  = 2'd1,
        FLD_LEN  = 2'd2,
        FLD_BASE = 2'd3
    } agu_field_e;
endpackage

// File: rtl/dsp_agu_regfile.sv
// Module: register sets (pointer, modify, length, base) with one config
// write port, one pointer write-back port and one combinational read port.
// Assumes NREG is a power of two; a config write wins over write-back.
module dsp_agu_regfile
    import dsp_agu_pkg::*;
#(
    parameter int NREG  = 8,
    parameter int AW    = 32,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [1:0]       cfg_fld,
    input  logic [AW-1:0]    cfg_data,
    input  logic             wb_en,
    input  logic [SEL_W-1:0] wb_sel,
    input  logic [AW-1:0]    wb_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [AW-1:0]    rd_ptr,
    output logic [AW-1:0]    rd_mod,
    output logic [AW-1:0]    rd_len,
    output logic [AW-1:0]    rd_base
);
    logic [AW-1:0] ptr_q  [NREG];
    logic [AW-1:0] mod_q  [NREG];
    logic [AW-1:0] len_q  [NREG];
    logic [AW-1:0] base_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_set
        logic hit_cfg;
        logic hit_wb;
        assign hit_cfg = cfg_we && (cfg_sel == SEL_W'(g));
        assign hit_wb  = wb_en  && (wb_sel  == SEL_W'(g));

        // Purpose: hold one register set; config write or pointer write-back.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr_q[g]  <= '0;
                mod_q[g]  <= '0;
                len_q[g]  <= '0;
                base_q[g] <= '0;
            end else if (hit_cfg) begin
                case (agu_field_e'(cfg_fld))
                    FLD_PTR:  ptr_q[g]  <= cfg_data;
                    FLD_MOD:  mod_q[g]  <= cfg_data;
                    FLD_LEN:  len_q[g]  <= cfg_data;
                    default:  base_q[g] <= cfg_data;
                endcase
            end else if (hit_wb) begin
                ptr_q[g] <= wb_data;
            end
        end
    end

    assign rd_ptr  = ptr_q[rd_sel];
    assign rd_mod  = mod_q[rd_sel];
    assign rd_len  = len_q[rd_sel];
    assign rd_base = base_q[rd_sel];
endmodule

// File: rtl/dsp_agu_align.sv
// Module: alignment check of an output address against the access size.
// Assumes only the two low address bits matter; size code 3 always faults.
module dsp_agu_align
    import dsp_agu_pkg::*;
(
    input  logic [1:0] addr_lo,
    input  logic [1:0] size,
    output logic       fault
);
    // Purpose: flag misaligned half/word accesses and the invalid size.
    always_comb begin
        case (agu_size_e'(size))
            SZ_BYTE: fault = 1'b0;
            SZ_HALF: fault = addr_lo[0];
            SZ_WORD: fault = |addr_lo;
            default: fault = 1'b1;
        endcase
    end
endmodule

// File: rtl/dsp_agu_calc.sv
// Module: combinational address and pointer-update computation for one request.
// Assumes circular windows do not straddle the top of the address space.
module dsp_agu_calc
    import dsp_agu_pkg::*;
#(
    parameter int AW    = 32,
    parameter int IMM_W = 16
) (
    input  logic [2:0]       mode,
    input  logic [1:0]       size,
    input  logic [IMM_W-1:0] imm,
    input  logic [AW-1:0]    ptr,
    input  logic [AW-1:0]    mod,
    input  logic [AW-1:0]    len,
    input  logic [AW-1:0]    base,
    output logic [AW-1:0]    addr,
    output logic [AW-1:0]    new_ptr,
    output logic             wants_wb
);
    logic [AW-1:0] step_sz;
    logic [AW-1:0] imm_ext;
    logic [AW-1:0] lin_inc;
    logic [AW-1:0] lin_dec;
    logic [AW-1:0] circ_raw;
    logic [AW-1:0] circ_lim;
    logic [AW-1:0] circ_new;
    logic [AW-1:0] rev_p;
    logic [AW-1:0] rev_m;
    logic [AW-1:0] rev_sum;
    logic [AW-1:0] br_new;

    // Purpose: byte count of the access (invalid code treated as a word).
    always_comb begin
        case (agu_size_e'(size))
            SZ_BYTE: step_sz = AW'(1);
            SZ_HALF: step_sz = AW'(2);
            default: step_sz = AW'(4);
        endcase
    end

    assign imm_ext = {{(AW-IMM_W){imm[IMM_W-1]}}, imm};
    assign lin_inc = ptr + step_sz;
    assign lin_dec = ptr - step_sz;

    // Purpose: pick the unwrapped update for the circular-capable modes.
    always_comb begin
        case (agu_mode_e'(mode))
            AM_POSTINC: circ_raw = lin_inc;
            AM_POSTDEC: circ_raw = lin_dec;
            default:    circ_raw = ptr + mod;
        endcase
    end

    assign circ_lim = base + len;

    // Purpose: fold the update back into the window base..base+len-1.
    always_comb begin
        if (len == '0)                circ_new = circ_raw;
        else if (circ_raw >= circ_lim) circ_new = circ_raw - len;
        else if (circ_raw < base)      circ_new = circ_raw + len;
        else                           circ_new = circ_raw;
    end

    // Bit-reversed update: reverse, add, reverse back.
    for (genvar b = 0; b < AW; b++) begin : g_rev
        assign rev_p[b]  = ptr[AW-1-b];
        assign rev_m[b]  = mod[AW-1-b];
        assign br_new[b] = rev_sum[AW-1-b];
    end
    assign rev_sum = rev_p + rev_m;

    // Purpose: select output address and write-back value per mode.
    always_comb begin
        addr     = ptr;
        new_ptr  = ptr;
        wants_wb = 1'b0;
        case (agu_mode_e'(mode))
            AM_IND:    ;
            AM_POSTINC, AM_POSTDEC, AM_MODIFY: begin
                new_ptr  = circ_new;
                wants_wb = 1'b1;
            end
            AM_OFFSET: addr = ptr + imm_ext;
            AM_PUSH: begin
                addr     = lin_dec;
                new_ptr  = lin_dec;
                wants_wb = 1'b1;
            end
            AM_POP: begin
                new_ptr  = lin_inc;
                wants_wb = 1'b1;
            end
            default: begin
                new_ptr  = br_new;
                wants_wb = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/dsp_agu.sv
// Module: top of the address generation unit. One request per cycle; result
// registered one cycle later together with the pointer write-back.
// Assumes a config write and a request never share a cycle.
module dsp_agu
    import dsp_agu_pkg::*;
#(
    parameter int NREG  = 8,
    parameter int AW    = 32,
    parameter int IMM_W = 16,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we_i,
    input  logic [SEL_W-1:0] cfg_sel_i,
    input  logic [1:0]       cfg_fld_i,
    input  logic [AW-1:0]    cfg_data_i,
    input  logic             req_i,
    input  logic [2:0]       mode_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [1:0]       size_i,
    input  logic [IMM_W-1:0] imm_i,
    output logic [AW-1:0]    addr_o,
    output logic             valid_o,
    output logic             fault_o
);
    logic [AW-1:0] rd_ptr;
    logic [AW-1:0] rd_mod;
    logic [AW-1:0] rd_len;
    logic [AW-1:0] rd_base;
    logic [AW-1:0] calc_addr;
    logic [AW-1:0] calc_new;
    logic          calc_wb;
    logic          align_fault;
    logic          wb_en;

    dsp_agu_regfile #(.NREG(NREG), .AW(AW)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we_i),
        .cfg_sel  (cfg_sel_i),
        .cfg_fld  (cfg_fld_i),
        .cfg_data (cfg_data_i),
        .wb_en    (wb_en),
        .wb_sel   (sel_i),
        .wb_data  (calc_new),
        .rd_sel   (sel_i),
        .rd_ptr   (rd_ptr),
        .rd_mod   (rd_mod),
        .rd_len   (rd_len),
        .rd_base  (rd_base)
    );

    dsp_agu_calc #(.AW(AW), .IMM_W(IMM_W)) calc_i (
        .mode     (mode_i),
        .size     (size_i),
        .imm      (imm_i),
        .ptr      (rd_ptr),
        .mod      (rd_mod),
        .len      (rd_len),
        .base     (rd_base),
        .addr     (calc_addr),
        .new_ptr  (calc_new),
        .wants_wb (calc_wb)
    );

    dsp_agu_align align_i (
        .addr_lo (calc_addr[1:0]),
        .size    (size_i),
        .fault   (align_fault)
    );

    assign wb_en = req_i && calc_wb && !align_fault;

    // Purpose: register the response of the current request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o  <= '0;
            valid_o <= 1'b0;
            fault_o <= 1'b0;
        end else begin
            valid_o <= req_i;
            fault_o <= req_i && align_fault;
            if (req_i) addr_o <= calc_addr;
        end
    end
endmodule

// File: rtl/dsp_agu_chk.sv
// Module: assertion checker for dsp_agu, attached by bind below.
// Assumes the input rules stated in the brief.
module dsp_agu_chk #(
    parameter int AW    = 32,
    parameter int SEL_W = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we_i,
    input logic          req_i,
    input logic [2:0]    mode_i,
    input logic [1:0]    size_i,
    input logic [AW-1:0] addr_o,
    input logic          valid_o,
    input logic          fault_o,
    input logic          wb_en
);
    a_r1_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> valid_o);
    a_r1_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> (!valid_o && !fault_o));
    a_r8_fault_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> valid_o);
    a_r8_bad_size_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && size_i == 2'd3) |=> fault_o);
    a_r8_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !fault_o && $past(size_i) == 2'd2) |-> (addr_o[1:0] == 2'b00));
    a_r8_half_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !fault_o && $past(size_i) == 2'd1) |-> !addr_o[0]);
    a_r2_ind_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && (mode_i == 3'd0 || mode_i == 3'd3)) |-> !wb_en);
    a_r9_cfg_req_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we_i && req_i));
endmodule

bind dsp_agu dsp_agu_chk #(.AW(AW), .SEL_W(SEL_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we_i (cfg_we_i),
    .req_i    (req_i),
    .mode_i   (mode_i),
    .size_i   (size_i),
    .addr_o   (addr_o),
    .valid_o  (valid_o),
    .fault_o  (fault_o),
    .wb_en    (wb_en)
);

// File: tb/dsp_agu_tb_top.sv
module dsp_agu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic [2:0]  cfg_sel_i = '0;
    logic [1:0]  cfg_fld_i = '0;
    logic [31:0] cfg_data_i = '0;
    logic        req_i = 1'b0;
    logic [2:0]  mode_i = '0;
    logic [2:0]  sel_i = '0;
    logic [1:0]  size_i = '0;
    logic [15:0] imm_i = '0;
    logic [31:0] addr_o;
    logic        valid_o;
    logic        fault_o;

    int checks = 0;
    int fails  = 0;
    bit started = 0;

    always #10 clk = ~clk;

    dsp_agu dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_fld_i(cfg_fld_i), .cfg_data_i(cfg_data_i),
        .req_i(req_i), .mode_i(mode_i), .sel_i(sel_i), .size_i(size_i), .imm_i(imm_i),
        .addr_o(addr_o), .valid_o(valid_o), .fault_o(fault_o)
    );

    // Behavioural reference model
    logic [31:0] m_ptr [8];
    logic [31:0] m_mod [8];
    logic [31:0] m_len [8];
    logic [31:0] m_base[8];
    logic        e_valid = 0;
    logic [31:0] e_addr = 0;
    logic        e_fault = 0;
    string       e_tag = "R1";

    function automatic logic [31:0] rev_carry_add(logic [31:0] a, logic [31:0] b);
        logic [31:0] r;
        logic c = 1'b0;
        for (int k = 31; k >= 0; k--) begin
            r[k] = a[k] ^ b[k] ^ c;
            c = (a[k] & b[k]) | (c & (a[k] ^ b[k]));
        end
        return r;
    endfunction

    function automatic logic [31:0] wrap(logic [31:0] v, logic [31:0] b, logic [31:0] l);
        longint unsigned vv = v;
        longint unsigned top = longint'(b) + longint'(l);
        if (l == 0) return v;
        if (vv >= top) return v - l;
        if (vv < longint'(b)) return v + l;
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin
                m_ptr[i] = 0; m_mod[i] = 0; m_len[i] = 0; m_base[i] = 0;
            end
            e_valid = 0; e_fault = 0; e_addr = 0; e_tag = "R1";
        end else begin
            if (cfg_we_i) begin
                case (cfg_fld_i)
                    2'd0: m_ptr[cfg_sel_i]  = cfg_data_i;
                    2'd1: m_mod[cfg_sel_i]  = cfg_data_i;
                    2'd2: m_len[cfg_sel_i]  = cfg_data_i;
                    default: m_base[cfg_sel_i] = cfg_data_i;
                endcase
            end
            e_valid = req_i;
            e_fault = 0;
            if (req_i) begin
                logic [31:0] p, a, n, sz;
                bit upd;
                p = m_ptr[sel_i];
                sz = (size_i == 0) ? 1 : (size_i == 1) ? 2 : 4;
                a = p; n = p; upd = 0;
                case (mode_i)
                    3'd0: e_tag = "R2";
                    3'd1: begin n = wrap(p + sz, m_base[sel_i], m_len[sel_i]); upd = 1; e_tag = "R3"; end
                    3'd2: begin n = wrap(p - sz, m_base[sel_i], m_len[sel_i]); upd = 1; e_tag = "R3"; end
                    3'd3: begin a = p + {{16{imm_i[15]}}, imm_i}; e_tag = "R4"; end
                    3'd4: begin a = p - sz; n = a; upd = 1; e_tag = "R5"; end
                    3'd5: begin n = p + sz; upd = 1; e_tag = "R5"; end
                    3'd6: begin n = wrap(p + m_mod[sel_i], m_base[sel_i], m_len[sel_i]); upd = 1; e_tag = "R6"; end
                    default: begin n = rev_carry_add(p, m_mod[sel_i]); upd = 1; e_tag = "R7"; end
                endcase
                e_fault = (size_i == 3) || (size_i == 1 && a[0]) || (size_i == 2 && a[1:0] != 0);
                if (e_fault) e_tag = "R8";
                e_addr = a;
                if (upd && !e_fault) m_ptr[sel_i] = n;
            end
        end
    end

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (started) begin
            checks++;
            if (valid_o !== e_valid) begin
                fails++;
                $display("FAIL R1 valid act=%0b exp=%0b", valid_o, e_valid);
            end else if (e_valid && (addr_o !== e_addr || fault_o !== e_fault)) begin
                fails++;
                $display("FAIL %s addr act=%h exp=%h fault act=%0b exp=%0b",
                         e_tag, addr_o, e_addr, fault_o, e_fault);
            end else if (!e_valid && fault_o !== 1'b0) begin
                fails++;
                $display("FAIL R1 idle fault act=%0b exp=0", fault_o);
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic cfg(input int s, input int f, input logic [31:0] d);
        @(negedge clk);
        req_i = 0;
        cfg_we_i = 1; cfg_sel_i = 3'(s); cfg_fld_i = 2'(f); cfg_data_i = d;
        @(negedge clk);
        cfg_we_i = 0;
    endtask

    task automatic rq(input int s, input int m, input int z, input logic [15:0] im);
        @(negedge clk);
        cfg_we_i = 0;
        req_i = 1; sel_i = 3'(s); mode_i = 3'(m); size_i = 2'(z); imm_i = im;
        @(posedge clk); #1;
        req_i = 0;
    endtask

    task automatic idle();
        @(negedge clk);
        req_i = 0; cfg_we_i = 0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset valid", {31'b0, valid_o}, 0);
        check("R1 reset fault", {31'b0, fault_o}, 0);
        check("R1 reset addr", addr_o, 0);
        @(negedge clk);
        rst_n = 1;
        started = 1;

        // R9: reset clears fields; config write visible next cycle
        rq(1, 0, 2, 0);           check("R9 cleared ptr", addr_o, 0);
        cfg(1, 0, 32'h1000);
        rq(1, 0, 2, 0);           check("R9/R2 ind", addr_o, 32'h1000);
        rq(1, 0, 2, 0);           check("R2 unchanged", addr_o, 32'h1000);

        // R3 post-inc/dec, back to back (R1)
        rq(1, 1, 2, 0);           check("R3 postinc old", addr_o, 32'h1000);
        rq(1, 1, 2, 0);           check("R3 postinc next", addr_o, 32'h1004);
        rq(1, 2, 1, 0);           check("R3 postdec half", addr_o, 32'h1008);
        rq(1, 0, 0, 0);           check("R3 after dec", addr_o, 32'h1006);
        idle();
        @(posedge clk); #1;       check("R1 idle valid", {31'b0, valid_o}, 0);

        // R5 push/pop and R4 offset
        cfg(5, 0, 32'h400);
        rq(5, 4, 2, 0);           check("R5 push addr", addr_o, 32'h3FC);
        rq(5, 0, 2, 0);           check("R5 push wb", addr_o, 32'h3FC);
        rq(5, 5, 2, 0);           check("R5 pop addr", addr_o, 32'h3FC);
        rq(5, 0, 2, 0);           check("R5 pop wb", addr_o, 32'h400);
        rq(5, 3, 2, 16'hFFFC);    check("R4 neg offset", addr_o, 32'h3FC);
        rq(5, 3, 0, 16'h0011);    check("R4 pos offset", addr_o, 32'h411);
        rq(5, 0, 2, 0);           check("R4 no update", addr_o, 32'h400);

        // R6 circular wrap both directions
        cfg(2, 3, 32'h200); cfg(2, 2, 32'h10); cfg(2, 0, 32'h20C); cfg(2, 1, 32'h8);
        rq(2, 6, 2, 0);           check("R6 modify old", addr_o, 32'h20C);
        rq(2, 0, 2, 0);           check("R6 wrap high", addr_o, 32'h204);
        cfg(2, 1, 32'hFFFF_FFF8);
        rq(2, 6, 2, 0);           check("R6 modify neg", addr_o, 32'h204);
        rq(2, 0, 2, 0);           check("R6 wrap low", addr_o, 32'h20C);
        cfg(6, 0, 32'h0FFC); cfg(6, 1, 32'h8);
        rq(6, 6, 2, 0);           rq(6, 0, 2, 0);
        check("R6 zero length no wrap", addr_o, 32'h1004);

        // R7 bit-reversed sequence 0,8,4,12,2
        cfg(3, 0, 0); cfg(3, 1, 32'h8);
        rq(3, 7, 0, 0);           check("R7 br0", addr_o, 0);
        rq(3, 7, 0, 0);           check("R7 br1", addr_o, 8);
        rq(3, 7, 0, 0);           check("R7 br2", addr_o, 4);
        rq(3, 7, 0, 0);           check("R7 br3", addr_o, 12);
        rq(3, 7, 0, 0);           check("R7 br4", addr_o, 2);

        // R8 alignment faults and suppressed write-back
        cfg(4, 0, 32'h301);
        rq(4, 1, 2, 0);           check("R8 word fault", {31'b0, fault_o}, 1);
        check("R8 fault addr", addr_o, 32'h301);
        rq(4, 0, 0, 0);           check("R8 wb suppressed", addr_o, 32'h301);
        check("R8 byte ok", {31'b0, fault_o}, 0);
        rq(4, 0, 1, 0);           check("R8 half fault", {31'b0, fault_o}, 1);
        rq(4, 1, 0, 0);           rq(4, 0, 1, 0);
        check("R8 half aligned", {31'b0, fault_o}, 0);
        rq(4, 0, 3, 0);           check("R8 bad size", {31'b0, fault_o}, 1);

        // Random traffic on free and circular sets, compared every cycle
        cfg(6, 1, 32'h0000_0123);
        cfg(2, 1, 32'h4);
        for (int i = 0; i < 600; i++) begin
            int s;
            int m;
            if (i % 50 == 0) cfg(6, 1, $urandom);
            s = ($urandom % 2 == 0) ? 6 : 2;
            m = $urandom % 8;
            if (s == 2 && (m == 4 || m == 5 || m == 7)) m = 6;
            @(negedge clk);
            req_i = ($urandom % 5 != 0);
            sel_i = 3'(s); mode_i = 3'(m); size_i = 2'($urandom % 4);
            imm_i = 16'($urandom);
        end
        idle();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule